// File: doc/BRIEF.md
# Pipelined Serial ADC Readout Controller

This block is a serial-bus master that reads a 14-bit converter over a four-wire link. In the same exchange it writes the converter's input multiplexer setting. A start request latches a 3-bit channel code. The controller then waits until the converter's end-of-conversion line is high. It then lowers chip select and clocks one unbroken 16-bit frame. On the outgoing line, the frame carries a zero byte and then a command byte, which holds the channel code with the mux enable bit set. The incoming 16 bits are shifted right by two places, and the result is presented as a right-justified 14-bit value together with a one-clock valid strobe.

The converter is pipelined, so a frame returns the result of an earlier conversion while it programs the channel for a later one. Results therefore lag the channel selection. The frame that follows a reset returns meaningless data, and the controller does not flag it as valid. The serial clock comes from the system clock through a parameterised divider, which keeps the serial clock at or below the converter's limit. Chip select stays high for at least one serial clock period between frames. A start request that arrives inside that gap is held and served once the gap ends.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and busy and valid are low.
- R2: While end-of-conversion is low, chip select stays high and no frame begins. Chip select falls only in the clock after end-of-conversion has been seen high.
- R3: A frame holds chip select low without a break for exactly 16 rising serial clock edges. The serial clock is low whenever chip select is high.
- R4: The serial clock period is 2*CLK_DIV system clocks.
- R5: The outgoing word is sent MSB first. Bits 15:8 are 0x00. Bits 7:4 are zero, bit 3 is 1 (mux enable), and bits 2:0 hold the channel code latched at the start request. The outgoing line changes only on falling serial clock edges and is stable at every rising edge.
- R6: The incoming line is sampled on rising serial clock edges, MSB first. The first byte received holds result bits 13:6. The upper six bits of the second byte hold result bits 5:0. The result equals the 16-bit received word shifted right by two, so the last two bits received are dropped.
- R7: The first frame after any reset does not assert valid.
- R8: Valid is high for exactly one clock, in the clock in which chip select returns high. The result stays unchanged until the next frame ends.
- R9: Busy rises in the clock after an accepted start request. It stays high while chip select is low and falls together with the rise of chip select, unless another request is pending.
- R10: Chip select stays high for at least one serial clock period between frames. A start request made during that interval is held, and its frame follows the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request for one readout frame |
| chan_i | input | 3 | Mux channel code to program in the requested frame |
| eoc_i | input | 1 | Converter end-of-conversion, high when data is ready |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the converter |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| busy_o | output | 1 | High from an accepted request until its frame releases select |
| result_o | output | 14 | Right-justified conversion result |
| valid_o | output | 1 | One-clock strobe marking a new valid result |

## Verification
Busy is due one clock after the edge that samples a start request. Chip select falls one clock after end-of-conversion is sampled high in the waiting state. Each serial clock half-period lasts CLK_DIV clocks. Valid, the new result, the release of chip select and the fall of busy all appear on the edge that lowers the sixteenth serial clock pulse. The bench therefore waits for the rise of chip select and samples every result on the next falling system clock edge, then checks one clock later that valid has dropped and the result is held. A bench model of the converter changes its data line on falling serial clock edges and captures the command bits on rising ones, so sampling stays clear of the edges where the design's registers change.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_BITS = 16;
    localparam int BYTE_BITS  = 8;
    localparam int RES_BITS   = 14;
    localparam int CH_BITS    = 3;
    localparam int PAD_BITS   = FRAME_BITS - RES_BITS;
    localparam int CNT_BITS   = $clog2(FRAME_BITS);

    localparam logic [BYTE_BITS-1:0] MUX_ENABLE = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_SETUP = 3'd2,
        ST_SHIFT = 3'd3,
        ST_GAP   = 3'd4
    } rd_state_e;

    typedef struct packed {
        rd_state_e               st;
        logic                    cs_n;
        logic                    sck;
        logic                    busy;
        logic                    pend;
        logic                    first;
        logic                    valid;
        logic                    gap;
        logic [CNT_BITS-1:0]     bit_cnt;
        logic [CH_BITS-1:0]      chan;
        logic [RES_BITS-1:0]     result;
    } rd_ctl_t;

    // Outgoing frame: zero byte, then channel code with mux enable set.
    function automatic logic [FRAME_BITS-1:0] build_cmd(input logic [CH_BITS-1:0] ch);
        logic [BYTE_BITS-1:0] cmd;
        cmd = MUX_ENABLE | BYTE_BITS'(ch);
        return {{BYTE_BITS{1'b0}}, cmd};
    endfunction

endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_rd_shreg.sv
module adc_rd_shreg
    import adc_rd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [FRAME_BITS-1:0] load_word_i,
    input  logic                  shift_i,
    input  logic                  capture_i,
    input  logic                  miso_i,
    output logic                  mosi_o,
    output logic [RES_BITS-1:0]   rx_res_o
);
    logic [FRAME_BITS-1:0] tx_d, tx_q;
    logic [FRAME_BITS-1:0] rx_d, rx_q;

    always_comb begin
        tx_d = tx_q;
        rx_d = rx_q;
        if (load_i) begin
            tx_d = load_word_i;
            rx_d = '0;
        end else begin
            if (shift_i) begin
                tx_d = {tx_q[FRAME_BITS-2:0], 1'b0};
            end
            if (capture_i) begin
                rx_d = {rx_q[FRAME_BITS-2:0], miso_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign mosi_o   = tx_q[FRAME_BITS-1];
    assign rx_res_o = rx_q[FRAME_BITS-1:PAD_BITS];

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int CLK_DIV = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2:0]          chan_i,
    input  logic                eoc_i,
    output logic                sck_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic                cs_n_o,
    output logic                busy_o,
    output logic [13:0]         result_o,
    output logic                valid_o
);
    localparam logic [CNT_BITS-1:0] LAST_BIT = CNT_BITS'(FRAME_BITS - 1);

    rd_ctl_t ctl_d, ctl_q;

    logic                  run;
    logic                  tick;
    logic                  load;
    logic                  shift;
    logic                  capture;
    logic                  take;
    logic [RES_BITS-1:0]   rx_res;

    assign run = (ctl_q.st == ST_SETUP) || (ctl_q.st == ST_SHIFT) || (ctl_q.st == ST_GAP);

    adc_rd_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    adc_rd_shreg u_shreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_word_i (build_cmd(ctl_q.chan)),
        .shift_i     (shift),
        .capture_i   (capture),
        .miso_i      (miso_i),
        .mosi_o      (mosi_o),
        .rx_res_o    (rx_res)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        load        = 1'b0;
        shift       = 1'b0;
        capture     = 1'b0;
        take        = start_i && !ctl_q.pend;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.chan = chan_i;
                    ctl_d.busy = 1'b1;
                    ctl_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (eoc_i) begin
                    ctl_d.cs_n    = 1'b0;
                    ctl_d.bit_cnt = '0;
                    ctl_d.st      = ST_SETUP;
                    load          = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    ctl_d.sck = 1'b1;
                    capture   = 1'b1;
                    ctl_d.st  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (ctl_q.sck) begin
                        ctl_d.sck = 1'b0;
                        if (ctl_q.bit_cnt == LAST_BIT) begin
                            ctl_d.cs_n   = 1'b1;
                            ctl_d.busy   = 1'b0;
                            ctl_d.result = rx_res;
                            ctl_d.valid  = !ctl_q.first;
                            ctl_d.first  = 1'b0;
                            ctl_d.gap    = 1'b0;
                            ctl_d.st     = ST_GAP;
                        end else begin
                            ctl_d.bit_cnt = ctl_q.bit_cnt + 1'b1;
                            shift         = 1'b1;
                        end
                    end else begin
                        ctl_d.sck = 1'b1;
                        capture   = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (take) begin
                    ctl_d.pend = 1'b1;
                    ctl_d.chan = chan_i;
                    ctl_d.busy = 1'b1;
                end
                if (tick) begin
                    if (ctl_q.gap) begin
                        ctl_d.st   = (ctl_q.pend || take) ? ST_WAIT : ST_IDLE;
                        ctl_d.pend = 1'b0;
                        ctl_d.gap  = 1'b0;
                    end else begin
                        ctl_d.gap = 1'b1;
                    end
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.st      <= ST_IDLE;
            ctl_q.cs_n    <= 1'b1;
            ctl_q.first   <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sck_o    = ctl_q.sck;
    assign cs_n_o   = ctl_q.cs_n;
    assign busy_o   = ctl_q.busy;
    assign result_o = ctl_q.result;
    assign valid_o  = ctl_q.valid;

endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
    parameter int DIV = 25
) (
    input logic clk,
    input logic rst_n,
    input logic eoc_i,
    input logic sck_o,
    input logic mosi_o,
    input logic cs_n_o,
    input logic busy_o,
    input logic valid_o
);
    localparam int GAP_MIN = 2 * DIV;
    localparam int GW      = $clog2(GAP_MIN + 1) + 1;

    logic [GW-1:0] hi_cnt_q;
    logic          cs_prev_q;
    logic          ended_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q  <= GW'(GAP_MIN);
            cs_prev_q <= 1'b1;
            ended_q   <= 1'b0;
        end else begin
            cs_prev_q <= cs_n_o;
            if (cs_n_o && !cs_prev_q) begin
                ended_q <= 1'b1;
            end
            if (!cs_n_o) begin
                hi_cnt_q <= '0;
            end else if (hi_cnt_q < GW'(GAP_MIN)) begin
                hi_cnt_q <= hi_cnt_q + 1'b1;
            end
        end
    end

    p_eoc_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(eoc_i));

    p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);

    p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $rose(sck_o)) |-> $stable(mosi_o));

    p_no_first_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ended_q);

    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_valid_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && !cs_prev_q));

    p_busy_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_cnt_q >= GW'(GAP_MIN)));

endmodule

bind adc_rd_ctrl adc_rd_chk #(.DIV(CLK_DIV)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .eoc_i   (eoc_i),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .cs_n_o  (cs_n_o),
    .busy_o  (busy_o),
    .valid_o (valid_o)
);

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CD         = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  chan = 3'd0;
    logic        eoc = 1'b1;
    logic        miso = 1'b0;
    logic        sck_o, mosi_o, cs_n_o, busy_o, valid_o;
    logic [13:0] result_o;

    int checks = 0;
    int errors = 0;

    logic [15:0] slave_word = 16'h0;
    logic [15:0] sreg = 16'h0;
    logic [15:0] mosi_cap = 16'h0;
    int          rise_cnt = 0;
    int          per_err = 0;
    time         last_rise = 0;
    time         t_up = 0;
    time         gap_t = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_rd_ctrl #(.CLK_DIV(CD)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .chan_i   (chan),
        .eoc_i    (eoc),
        .sck_o    (sck_o),
        .mosi_o   (mosi_o),
        .miso_i   (miso),
        .cs_n_o   (cs_n_o),
        .busy_o   (busy_o),
        .result_o (result_o),
        .valid_o  (valid_o)
    );

    // Converter model: data changes on falling SCK, command captured on rising SCK.
    always @(negedge cs_n_o) begin
        sreg     = slave_word;
        miso     = sreg[15];
        rise_cnt = 0;
        per_err  = 0;
        mosi_cap = 16'h0;
        gap_t    = $time - t_up;
    end
    always @(posedge cs_n_o) t_up = $time;
    always @(negedge sck_o) begin
        if (cs_n_o === 1'b0) begin
            sreg = {sreg[14:0], 1'b0};
            miso = sreg[15];
        end
    end
    always @(posedge sck_o) begin
        if (cs_n_o === 1'b0) begin
            mosi_cap = {mosi_cap[14:0], mosi_o};
            if (rise_cnt > 0 && ($time - last_rise) != time'(2 * CD * CLK_PERIOD)) per_err++;
            last_rise = $time;
            rise_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n_o === 1'b1, "R1 cs_n", 32'(cs_n_o), 1);
        chk(sck_o === 1'b0, "R1 sck", 32'(sck_o), 0);
        chk(busy_o === 1'b0 && valid_o === 1'b0, "R1 busy/valid", {busy_o, valid_o}, 0);
    endtask

    task automatic issue(input logic [2:0] ch);
        @(negedge clk);
        start = 1'b1;
        chan  = ch;
        @(negedge clk);
        start = 1'b0;
        chan  = ~ch;
        chk(busy_o === 1'b1, "R9 busy after start", 32'(busy_o), 1);
    endtask

    task automatic finish_frame(input logic [2:0] ch, input logic [13:0] data, input bit expv);
        @(posedge cs_n_o);
        @(negedge clk);
        chk(rise_cnt == 16, "R3 sck pulses", 32'(rise_cnt), 16);
        chk(per_err == 0, "R4 sck period", 32'(per_err), 0);
        chk(mosi_cap === {8'h00, 5'b00001, ch}, "R5 command word", 32'(mosi_cap), {8'h00, 5'b00001, ch});
        chk(valid_o === expv, expv ? "R8 valid" : "R7 first frame", 32'(valid_o), 32'(expv));
        if (expv) chk(result_o === data, "R6 result", 32'(result_o), 32'(data));
        @(negedge clk);
        chk(valid_o === 1'b0, "R8 single pulse", 32'(valid_o), 0);
        if (expv) chk(result_o === data, "R8 result held", 32'(result_o), 32'(data));
    endtask

    task automatic run_frame(input logic [2:0] ch, input logic [13:0] data, input logic [1:0] junk,
                             input int dly, input bit expv);
        bit cs_ok;
        slave_word = {data, junk};
        if (dly > 0) eoc = 1'b0;
        issue(ch);
        cs_ok = 1'b1;
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            if (cs_n_o !== 1'b1 || busy_o !== 1'b1) cs_ok = 1'b0;
        end
        if (dly > 0) chk(cs_ok, "R2 hold while eoc low", 32'(cs_n_o), 1);
        eoc = 1'b1;
        finish_frame(ch, data, expv);
        chk(busy_o === 1'b0, "R9 busy released", 32'(busy_o), 0);
        repeat (2 * CD + 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R7: first frame after reset gives no valid result.
        run_frame(3'd5, 14'h1234, 2'b11, 12, 1'b0);

        // Sweep every channel across several data patterns and eoc delays.
        for (int ch = 0; ch < 8; ch++) begin
            for (int p = 0; p < 4; p++) begin
                logic [13:0] d;
                case (p)
                    0: d = 14'h0000;
                    1: d = 14'h3FFF;
                    2: d = 14'h2AAA ^ 14'(ch * 37);
                    default: d = 14'(ch * 1871 + 613);
                endcase
                run_frame(3'(ch), d, 2'(ch + p), (ch + p) % 3 * 5, 1'b1);
            end
        end

        // R10: back-to-back request during the inter-frame gap.
        slave_word = {14'h0F0F, 2'b10};
        issue(3'd2);
        @(posedge cs_n_o);
        @(negedge clk);
        chk(valid_o === 1'b1 && result_o === 14'h0F0F, "R6 b2b first result", 32'(result_o), 32'h0F0F);
        slave_word = {14'h3C3C, 2'b01};
        start = 1'b1;
        chan  = 3'd6;
        @(negedge clk);
        start = 1'b0;
        chan  = 3'd1;
        chk(busy_o === 1'b1, "R10 request held in gap", 32'(busy_o), 1);
        finish_frame(3'd6, 14'h3C3C, 1'b1);
        chk(gap_t >= time'(2 * CD * CLK_PERIOD), "R10 cs gap", 32'(gap_t), 32'(2 * CD * CLK_PERIOD));
        repeat (2 * CD + 2) @(negedge clk);

        // R7: a later reset again suppresses the first result.
        do_reset();
        run_frame(3'd7, 14'h2001, 2'b00, 3, 1'b0);
        run_frame(3'd0, 14'h1FFE, 2'b11, 0, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule